// File: doc/BRIEF.md
# Raster Line Interrupt Unit

This unit asks the CPU for an interrupt at a chosen scanline and at a chosen horizontal position inside that scanline. The video timing generator supplies the current scanline, the current dot within the line and a rendering-active flag. A one-cycle strobe marks each CPU cycle. Software programs a target line and a horizontal offset, enables the interrupt, and reads a status register. The status read both reports the raster flags and acknowledges the interrupt. A free-running jitter counter counts CPU cycles since the last interrupt. Software can read it to measure and compensate the latency of its interrupt handler.

The horizontal position is tracked with a dot accumulator. The accumulator is loaded with the current dot when the target line is reached. It then advances by the number of dots that pass per CPU cycle: 3 for 60 Hz timing and 3.2 for 50 Hz timing. It is held internally in fifths of a dot, so both rates are exact integers. The interrupt becomes due once the accumulator reaches twice the offset plus a lead-in of 24 dots (60 Hz) or 20 dots (50 Hz).

Control is a five-state machine:
- `ST_OFF`: out of frame.
- `ST_WATCH`: in frame, waiting for the target line.
- `ST_ARMED`: accumulating dots.
- `ST_READY`: position reached, interrupt not enabled.
- `ST_FIRED`: interrupt pending.

Transitions:
- OFF→WATCH on the first strobe with rendering active.
- WATCH→ARMED on a qualifying line match.
- ARMED→READY when the target is reached while disabled.
- ARMED→FIRED or READY→FIRED when the target is reached, or already reached, while enabled.
- ARMED, READY or FIRED→WATCH on a status read.
- FIRED→WATCH on a disable write.
- Any state→OFF on a strobe with rendering off or a scanline of 241 or more.

Top module: `raster_irq_unit`

## Requirements
- R1: After reset, `irq` and `in_frame` are low, the interrupt is disabled, the target line is 0, the offset is 135, the jitter count is 0, and no line counts as already triggered.
- R2: Register select 0 (write) stores the target line. Select 1 (write) enables the interrupt. Select 2 (write) disables it and clears a pending interrupt, so `irq` is low from the next cycle. A position reached while disabled stays held and fires on the first strobe after enabling.
- R3: A write to select 3 sets the horizontal offset, clamped to at most 169.
- R4: On a strobe with `render_on` low or `scanline` ≥ 241, `in_frame`, the pending interrupt and any armed or ready state clear, and the triggered-line record is forgotten.
- R5: On the first strobe with rendering active and a scanline below 241, `in_frame` rises and any pending interrupt is cleared.
- R6: Arming happens only on a strobe where `scanline` equals the target line, the unit is waiting (not armed, ready or pending) and that line has not already triggered since the last out-of-frame strobe.
- R7: On the arming strobe the accumulator takes the current dot. Each later strobe adds 3 dots (`pal_mode`=0) or 3.2 dots (`pal_mode`=1). The position is reached on the strobe where the sum is at least offset×2+24 (`pal_mode`=0) or offset×2+20 (`pal_mode`=1).
- R8: On a strobe where the position is reached (or held) and the interrupt is enabled, `irq` goes high after that edge and stays high until acknowledged, disabled or out of frame.
- R9: The jitter count increases by one on every strobe, wraps modulo 256, becomes 0 on the strobe that raises `irq`, and reads on select 4. Cycles without a strobe leave it unchanged.
- R10: A read of select 1 returns horizontal blank in bit 7, `in_frame` in bit 6 and pending in bit 0, with other bits 0. The read clears pending and any armed or ready state.
- R11: `hblank` is high exactly when `dot` ≥ 256.
- R12: After an interrupt is acknowledged, the same target line does not arm again until an out-of-frame strobe has occurred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_tick | input | 1 | One-cycle strobe per CPU cycle |
| scanline | input | 9 | Current scanline number |
| dot | input | 9 | Current dot within the line |
| render_on | input | 1 | Rendering enabled |
| pal_mode | input | 1 | 1 selects 50 Hz dot rate and lead-in |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_sel | input | 3 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational, zero when not reading) |
| irq | output | 1 | Interrupt request, active high |
| in_frame | output | 1 | Rendering-frame flag |
| hblank | output | 1 | Horizontal blank flag |

## Verification
Directed runs count the strobes from arming to `irq` for offsets 0, 135 and a clamped 169 at both dot rates. Together these separate the two step sizes, the two lead-ins and the clamp. Further directed sequences check that a held position waits for enable, that acknowledge blocks re-arming on the same line, and that vertical blank or disabled rendering clears everything. The jitter register is read across strobe gaps and past wrap. Constrained-random rasters with random strobe gaps, random register traffic and occasional rendering drop-outs are then compared every cycle against a bench model kept in tenths of a dot. This exposes ordering errors between strobe-driven updates and same-cycle bus accesses.

// File: rtl/raster_irq_pkg.sv
package raster_irq_pkg;

    typedef enum logic [2:0] {
        ST_OFF   = 3'd0,
        ST_WATCH = 3'd1,
        ST_ARMED = 3'd2,
        ST_READY = 3'd3,
        ST_FIRED = 3'd4
    } raster_state_e;

    localparam int SEL_W = 3;

    localparam logic [SEL_W-1:0] SEL_LINE    = 3'd0;
    localparam logic [SEL_W-1:0] SEL_CTRL    = 3'd1;
    localparam logic [SEL_W-1:0] SEL_DISABLE = 3'd2;
    localparam logic [SEL_W-1:0] SEL_OFFSET  = 3'd3;
    localparam logic [SEL_W-1:0] SEL_JITTER  = 3'd4;

endpackage

// File: rtl/raster_irq_regs.sv
module raster_irq_regs
    import raster_irq_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int OFFSET_MAX = 169,
    parameter int OFFSET_RST = 135
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [SEL_W-1:0]  bus_sel,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] line_q,
    output logic [DATA_W-1:0] offset_q,
    output logic              enable_q
);

    localparam logic [DATA_W-1:0] OFF_LIMIT = DATA_W'(OFFSET_MAX);
    localparam logic [DATA_W-1:0] OFF_INIT  = DATA_W'(OFFSET_RST);

    logic [DATA_W-1:0] offset_clamped;

    always_comb begin
        offset_clamped = (bus_wdata > OFF_LIMIT) ? OFF_LIMIT : bus_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q   <= '0;
            offset_q <= OFF_INIT;
            enable_q <= 1'b0;
        end else if (bus_wr) begin
            unique case (bus_sel)
                SEL_LINE:    line_q   <= bus_wdata;
                SEL_CTRL:    enable_q <= 1'b1;
                SEL_DISABLE: enable_q <= 1'b0;
                SEL_OFFSET:  offset_q <= offset_clamped;
                default:     ;
            endcase
        end
    end

endmodule

// File: rtl/raster_irq_dotacc.sv
module raster_irq_dotacc #(
    parameter int DOT_W     = 9,
    parameter int OFF_W     = 8,
    parameter int ACC_W     = 12,
    parameter int SCALE     = 5,
    parameter int NTSC_STEP = 15,
    parameter int PAL_STEP  = 16,
    parameter int NTSC_LEAD = 24,
    parameter int PAL_LEAD  = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             run,
    input  logic             pal_mode,
    input  logic [DOT_W-1:0] dot,
    input  logic [OFF_W-1:0] offset,
    output logic             reached
);

    localparam logic [ACC_W-1:0] STEP_N = ACC_W'(NTSC_STEP);
    localparam logic [ACC_W-1:0] STEP_P = ACC_W'(PAL_STEP);
    localparam logic [ACC_W-1:0] LEAD_N = ACC_W'(NTSC_LEAD);
    localparam logic [ACC_W-1:0] LEAD_P = ACC_W'(PAL_LEAD);
    localparam logic [ACC_W-1:0] MUL    = ACC_W'(SCALE);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_nx;
    logic [ACC_W-1:0] step;
    logic [ACC_W-1:0] goal_dots;
    logic [ACC_W-1:0] goal;
    logic [ACC_W-1:0] dot_scaled;

    always_comb begin
        step       = pal_mode ? STEP_P : STEP_N;
        goal_dots  = (ACC_W'(offset) << 1) + (pal_mode ? LEAD_P : LEAD_N);
        goal       = goal_dots * MUL;
        dot_scaled = ACC_W'(dot) * MUL;
        acc_nx     = arm ? dot_scaled : (acc_q + step);
        reached    = (arm || run) && (acc_nx >= goal);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (arm || run) begin
            acc_q <= acc_nx;
        end
    end

endmodule

// File: rtl/raster_irq_fsm.sv
module raster_irq_fsm
    import raster_irq_pkg::*;
#(
    parameter int LINE_W    = 9,
    parameter int TGT_W     = 8,
    parameter int JIT_W     = 8,
    parameter int VBL_LINE  = 241,
    parameter int NONE_LINE = 255
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              render_on,
    input  logic [LINE_W-1:0] scanline,
    input  logic [TGT_W-1:0]  target_line,
    input  logic              enable,
    input  logic              reached,
    input  logic              ack,
    input  logic              disable_wr,
    output logic              arm,
    output logic              run,
    output logic              irq,
    output logic              in_frame,
    output logic [JIT_W-1:0]  jitter
);

    localparam logic [LINE_W-1:0] LINE_VBL  = LINE_W'(VBL_LINE);
    localparam logic [LINE_W-1:0] LINE_NONE = LINE_W'(NONE_LINE);

    raster_state_e     state_q, state_tk, state_d, base;
    logic [LINE_W-1:0] last_q;
    logic [LINE_W-1:0] tgt_ext;
    logic              out_of_frame;
    logic              fire;

    always_comb begin
        tgt_ext      = LINE_W'(target_line);
        out_of_frame = !render_on || (scanline >= LINE_VBL);
        base         = (state_q == ST_OFF) ? ST_WATCH : state_q;
        arm          = tick && !out_of_frame && (base == ST_WATCH) &&
                       (scanline == tgt_ext) && (scanline != last_q);
        run          = tick && !out_of_frame && (base == ST_ARMED);

        state_tk = state_q;
        if (tick) begin
            if (out_of_frame) begin
                state_tk = ST_OFF;
            end else begin
                unique case (base)
                    ST_WATCH: begin
                        if (arm)
                            state_tk = reached ? (enable ? ST_FIRED : ST_READY) : ST_ARMED;
                        else
                            state_tk = ST_WATCH;
                    end
                    ST_ARMED: state_tk = reached ? (enable ? ST_FIRED : ST_READY) : ST_ARMED;
                    ST_READY: state_tk = enable ? ST_FIRED : ST_READY;
                    ST_FIRED: state_tk = ST_FIRED;
                    default:  state_tk = ST_OFF;
                endcase
            end
        end
        fire = (state_tk == ST_FIRED) && (state_q != ST_FIRED);

        state_d = state_tk;
        if (ack && (state_tk inside {ST_ARMED, ST_READY, ST_FIRED}))
            state_d = ST_WATCH;
        if (disable_wr && (state_tk == ST_FIRED))
            state_d = ST_WATCH;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            last_q  <= LINE_NONE;
            jitter  <= '0;
        end else begin
            state_q <= state_d;
            if (tick) begin
                if (out_of_frame)
                    last_q <= LINE_NONE;
                else if (reached)
                    last_q <= tgt_ext;
                jitter <= fire ? '0 : jitter + 1'b1;
            end
        end
    end

    always_comb begin
        irq      = (state_q == ST_FIRED);
        in_frame = (state_q != ST_OFF);
    end

endmodule

// File: rtl/raster_irq_unit.sv
module raster_irq_unit
    import raster_irq_pkg::*;
#(
    parameter int LINE_W     = 9,
    parameter int DOT_W      = 9,
    parameter int DATA_W     = 8,
    parameter int JIT_W      = 8,
    parameter int ACC_W      = 12,
    parameter int OFFSET_MAX = 169,
    parameter int OFFSET_RST = 135,
    parameter int VBL_LINE   = 241,
    parameter int HBLANK_DOT = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_tick,
    input  logic [LINE_W-1:0] scanline,
    input  logic [DOT_W-1:0]  dot,
    input  logic              render_on,
    input  logic              pal_mode,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [SEL_W-1:0]  bus_sel,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              in_frame,
    output logic              hblank
);

    localparam logic [DOT_W-1:0] DOT_HB = DOT_W'(HBLANK_DOT);

    logic [DATA_W-1:0] line_q;
    logic [DATA_W-1:0] offset_q;
    logic              enable_q;
    logic              arm, run, reached;
    logic              ack, disable_wr;
    logic [JIT_W-1:0]  jitter;
    logic [DATA_W-1:0] status;

    assign ack        = bus_rd && (bus_sel == SEL_CTRL);
    assign disable_wr = bus_wr && (bus_sel == SEL_DISABLE);
    assign hblank     = (dot >= DOT_HB);

    raster_irq_regs #(
        .DATA_W     (DATA_W),
        .OFFSET_MAX (OFFSET_MAX),
        .OFFSET_RST (OFFSET_RST)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_sel   (bus_sel),
        .bus_wdata (bus_wdata),
        .line_q    (line_q),
        .offset_q  (offset_q),
        .enable_q  (enable_q)
    );

    raster_irq_dotacc #(
        .DOT_W (DOT_W),
        .OFF_W (DATA_W),
        .ACC_W (ACC_W)
    ) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (arm),
        .run      (run),
        .pal_mode (pal_mode),
        .dot      (dot),
        .offset   (offset_q),
        .reached  (reached)
    );

    raster_irq_fsm #(
        .LINE_W   (LINE_W),
        .TGT_W    (DATA_W),
        .JIT_W    (JIT_W),
        .VBL_LINE (VBL_LINE)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (cpu_tick),
        .render_on   (render_on),
        .scanline    (scanline),
        .target_line (line_q),
        .enable      (enable_q),
        .reached     (reached),
        .ack         (ack),
        .disable_wr  (disable_wr),
        .arm         (arm),
        .run         (run),
        .irq         (irq),
        .in_frame    (in_frame),
        .jitter      (jitter)
    );

    always_comb begin
        status             = '0;
        status[DATA_W-1]   = hblank;
        status[DATA_W-2]   = in_frame;
        status[0]          = irq;
        bus_rdata          = '0;
        if (bus_rd) begin
            unique case (bus_sel)
                SEL_CTRL:   bus_rdata = status;
                SEL_JITTER: bus_rdata = DATA_W'(jitter);
                default:    bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/raster_irq_chk.sv
module raster_irq_chk
    import raster_irq_pkg::*;
#(
    parameter int LINE_W   = 9,
    parameter int DOT_W    = 9,
    parameter int DATA_W   = 8,
    parameter int JIT_W    = 8,
    parameter int VBL_LINE = 241,
    parameter int HB_DOT   = 256
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_tick,
    input logic              render_on,
    input logic [LINE_W-1:0] scanline,
    input logic [DOT_W-1:0]  dot,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [SEL_W-1:0]  bus_sel,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              irq,
    input logic              in_frame,
    input logic [JIT_W-1:0]  jitter
);

    // R4
    frame_exit_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_tick && (!render_on || scanline >= LINE_W'(VBL_LINE))) |=> (!in_frame && !irq));

    // R2
    disable_drops_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_sel == SEL_DISABLE) |=> !irq);

    // R10
    status_read_acks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_sel == SEL_CTRL) |=> !irq);

    // R8
    irq_rises_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(cpu_tick));

    // R9
    jitter_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_tick |=> $stable(jitter));

    // R5
    frame_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_frame) |-> $past(cpu_tick && render_on));

    // R11
    status_hblank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_sel == SEL_CTRL) |-> (bus_rdata[DATA_W-1] == (dot >= DOT_W'(HB_DOT))));

endmodule

bind raster_irq_unit raster_irq_chk #(
    .LINE_W   (LINE_W),
    .DOT_W    (DOT_W),
    .DATA_W   (DATA_W),
    .JIT_W    (JIT_W),
    .VBL_LINE (VBL_LINE),
    .HB_DOT   (HBLANK_DOT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_tick  (cpu_tick),
    .render_on (render_on),
    .scanline  (scanline),
    .dot       (dot),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_sel   (bus_sel),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .in_frame  (in_frame),
    .jitter    (jitter)
);

// File: tb/raster_irq_unit_tb.sv
module raster_irq_unit_tb;
    import raster_irq_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cpu_tick;
    logic [8:0] scanline;
    logic [8:0] dot;
    logic       render_on;
    logic       pal_mode;
    logic       bus_wr;
    logic       bus_rd;
    logic [2:0] bus_sel;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata;
    logic       irq;
    logic       in_frame;
    logic       hblank;

    always #10 clk = ~clk;

    raster_irq_unit u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_tick(cpu_tick), .scanline(scanline),
        .dot(dot), .render_on(render_on), .pal_mode(pal_mode),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_sel(bus_sel),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .in_frame(in_frame), .hblank(hblank)
    );

    int n_tests = 0;
    int n_fail  = 0;

    // bench model, positions in tenths of a dot
    bit m_inf, m_pend, m_en;
    int m_ready, m_acc, m_last, m_line, m_off, m_jit;

    task automatic chk(string req, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_status(int dv);
        return ((dv >= 256) ? 128 : 0) | (m_inf ? 64 : 0) | (m_pend ? 1 : 0);
    endfunction

    function automatic int exp_ticks(int off, bit pal);
        int s   = pal ? 32 : 30;
        int tgt = (off * 2 + (pal ? 20 : 24)) * 10;
        return (tgt + s - 1) / s + 1;
    endfunction

    task automatic model_reset();
        m_inf = 0; m_pend = 0; m_en = 0; m_ready = 0; m_acc = 0;
        m_last = 255; m_line = 0; m_off = 135; m_jit = 0;
    endtask

    task automatic model_step(bit tk, int ln, int dt, bit ren, bit pal,
                              bit wr, bit rd, int sel, int data);
        int s = pal ? 32 : 30;
        if (tk) begin
            m_jit = (m_jit + 1) % 256;
            if (!ren || ln >= 241) begin
                m_inf = 0; m_pend = 0; m_ready = 0; m_last = 255;
            end else begin
                if (!m_inf) begin m_inf = 1; m_pend = 0; end
                if (ln == m_line && m_ready == 0 && !m_pend && ln != m_last) begin
                    m_ready = 1; m_acc = dt * 10 - s;
                end
                if (m_ready == 1 && !m_pend) begin
                    m_acc += s;
                    if (m_acc >= (m_off * 2 + (pal ? 20 : 24)) * 10) begin
                        m_ready = 2; m_last = m_line;
                    end
                end
                if (m_en && !m_pend && m_ready == 2) begin
                    m_pend = 1; m_ready = 0; m_jit = 0;
                end
            end
        end
        if (wr) begin
            case (sel)
                0: m_line = data;
                1: m_en = 1;
                2: begin m_en = 0; m_pend = 0; end
                3: m_off = (data > 169) ? 169 : data;
                default: ;
            endcase
        end
        if (rd && sel == 1) begin m_pend = 0; m_ready = 0; end
    endtask

    // one clock: drive at negedge, check reads, model at the edge, check outputs after
    task automatic cyc(bit tk, int ln, int dt, bit ren, bit pal,
                       bit wr = 0, bit rd = 0, int sel = 0, int data = 0);
        int e;
        cpu_tick = tk; scanline = 9'(ln); dot = 9'(dt); render_on = ren;
        pal_mode = pal; bus_wr = wr; bus_rd = rd; bus_sel = 3'(sel);
        bus_wdata = 8'(data);
        #1;
        chk("R11", int'(hblank), (dt >= 256) ? 1 : 0);
        if (rd) begin
            e = (sel == 1) ? exp_status(dt) : (sel == 4) ? m_jit : 0;
            chk((sel == 4) ? "R9" : "R10", int'(bus_rdata), e);
        end
        @(posedge clk);
        model_step(tk, ln, dt, ren, pal, wr, rd, sel, data);
        @(negedge clk);
        chk("R8", int'(irq), int'(m_pend));
        chk("R5", int'(in_frame), int'(m_inf));
    endtask

    task automatic measure(int ln, bit pal, output int n);
        cyc(1, 0, 0, 0, pal);          // leave the frame, forget last line
        cyc(1, ln, 0, 1, pal);         // arming strobe
        n = 1;
        while (!irq && n < 400) begin
            cyc(1, ln, 0, 1, pal);
            n++;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int n, ln, dt, fr;
        void'($urandom(32'd4242));
        rst_n = 0;
        cpu_tick = 0; scanline = 0; dot = 0; render_on = 0; pal_mode = 0;
        bus_wr = 0; bus_rd = 0; bus_sel = 0; bus_wdata = 0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        chk("R1", int'(irq), 0);
        chk("R1", int'(in_frame), 0);
        cyc(0, 0, 0, 0, 0, 0, 1, 1);
        cyc(0, 0, 0, 0, 0, 0, 1, 4);
        // R1 default offset 135, R7 NTSC
        cyc(0, 0, 0, 0, 0, 1, 0, 0, 5);
        cyc(0, 0, 0, 0, 0, 1, 0, 1, 0);
        measure(5, 0, n);
        chk("R1", n, exp_ticks(135, 0));
        // R10 status read with pending, then acknowledge
        cyc(0, 5, 300, 1, 0, 0, 1, 1);
        chk("R10", int'(irq), 0);
        // R12 same line does not re-arm
        repeat (150) cyc(1, 5, 0, 1, 0);
        chk("R12", int'(irq), 0);

        // R7 offset 0, both rates
        cyc(0, 5, 0, 1, 0, 1, 0, 3, 0);
        measure(5, 0, n); chk("R7", n, exp_ticks(0, 0));
        cyc(0, 5, 0, 1, 0, 0, 1, 1);
        measure(5, 1, n); chk("R7", n, exp_ticks(0, 1));
        cyc(0, 5, 0, 1, 1, 0, 1, 1);
        // R3 clamp 200 -> 169
        cyc(0, 5, 0, 1, 0, 1, 0, 3, 200);
        measure(5, 0, n); chk("R3", n, exp_ticks(169, 0));
        cyc(0, 5, 0, 1, 0, 0, 1, 1);
        measure(5, 1, n); chk("R3", n, exp_ticks(169, 1));

        // R9 jitter after fire, gaps and wrap
        repeat (10) cyc(1, 5, 0, 1, 1);
        repeat (5) cyc(0, 5, 0, 1, 1);
        cyc(0, 5, 0, 1, 1, 0, 1, 4);
        chk("R9", int'(bus_rdata), 10);
        repeat (300) cyc(1, 5, 0, 1, 1);
        cyc(0, 5, 0, 1, 1, 0, 1, 4);
        chk("R9", int'(bus_rdata), 310 % 256);

        // R4 vertical blank clears pending and frame
        cyc(1, 241, 0, 1, 1);
        chk("R4", int'(irq), 0);
        chk("R4", int'(in_frame), 0);

        // R2 disable clears, held position fires on enable
        cyc(0, 0, 0, 1, 0, 1, 0, 3, 0);
        cyc(0, 0, 0, 1, 0, 1, 0, 2, 0);
        cyc(1, 0, 0, 0, 0);
        repeat (20) cyc(1, 5, 0, 1, 0);
        chk("R2", int'(irq), 0);
        cyc(0, 5, 0, 1, 0, 1, 0, 1, 0);
        cyc(1, 5, 0, 1, 0);
        chk("R2", int'(irq), 1);
        cyc(0, 5, 0, 1, 0, 1, 0, 2, 0);
        chk("R2", int'(irq), 0);

        // R6 other lines never arm
        cyc(0, 0, 0, 1, 0, 1, 0, 0, 20);
        cyc(0, 0, 0, 1, 0, 1, 0, 1, 0);
        cyc(1, 0, 0, 0, 0);
        repeat (60) cyc(1, 19, 0, 1, 0);
        chk("R6", int'(irq), 0);
        // R11 hblank in status
        cyc(0, 19, 300, 1, 0, 0, 1, 1);
        // R4 render off clears
        repeat (20) cyc(1, 20, 0, 1, 0);
        chk("R8", int'(irq), 1);
        cyc(1, 20, 0, 0, 0);
        chk("R4", int'(irq), 0);

        // constrained random rasters
        for (int f = 0; f < 6; f++) begin
            bit pal = f[0];
            ln = 0; dt = 0; fr = 0;
            while (ln < 76) begin
                bit tk = ($urandom % 8) != 0;
                bit ren = !(f == 3 && ln >= 30 && ln < 32);
                bit wr = 0, rd = 0;
                int sel = 0, data = 0;
                if (($urandom % 64) == 0) begin
                    sel = $urandom % 5;
                    rd = $urandom % 2;
                    wr = !rd;
                    data = (sel == 0) ? ($urandom % 70) : ($urandom % 256);
                end
                cyc(tk, (ln >= 70) ? 171 + ln : ln, dt, ren, pal, wr, rd, sel, data);
                if (tk) begin
                    dt += 3;
                    if (dt >= 341) begin dt -= 341; ln++; end
                end
            end
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule